// File: doc/BRIEF.md
# Frame-Restart Prefill Input Gate

This block sits in the video clock domain, between a clock-crossing pixel FIFO and a streaming image scaler. A frame-restart level comes in from a faster clock domain. The block passes it through a five-stage register chain, and the last stage acts as the local restart.

After every restart, the block keeps the scaler's input-valid low until the FIFO has shown data on enough cycles to build a safe margin. This stops the FIFO from draining right after a new frame begins. The FIFO read strobe is the scaler's request, qualified by that valid.

Pixels arrive from the FIFO as 16-bit 5-6-5 words. The block passes them to the scaler as 24-bit 8-8-8 samples, with each channel padded with zeros in its low bits.

Top module: `frame_prefill_gate`

## Requirements
- R1: `restart_async` reaches `frame_restart` after exactly five rising clock edges, for both its rise and its fall.
- R2: While `frame_restart` is high, the prefill count and the ready flag are held at zero. After `frame_restart` falls, the prefill therefore starts again from nothing.
- R3: The prefill count advances only on edges where `fifo_empty` is low, and it saturates at 60. Empty cycles add nothing.
- R4: The ready flag sets on an edge where the count is 60 and `fifo_empty` is low. Once set, it stays set through any number of empty cycles until the next restart.
- R5: `scaler_valid` is high exactly when `frame_restart` is low, `fifo_empty` is low and the ready flag is set. As a result, valid first rises on the 62nd non-empty cycle after a restart.
- R6: `fifo_rd_en` equals `scaler_next` AND `scaler_valid`. No read is issued during the prefill window, even when the scaler requests data.
- R7: `scaler_pixel[23:16]` is `fifo_rdata[15:11]` followed by three zeros. `scaler_pixel[15:8]` is `fifo_rdata[10:5]` followed by two zeros. `scaler_pixel[7:0]` is `fifo_rdata[4:0]` followed by three zeros.
- R8: A restart that arrives mid-frame closes the gate in the same cycle that `frame_restart` goes high. No further reads occur until a new prefill completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart_async | input | 1 | Frame-restart level from the other clock domain |
| fifo_empty | input | 1 | Empty flag of the upstream FIFO |
| fifo_rdata | input | 16 | 5-6-5 pixel at the FIFO head |
| scaler_next | input | 1 | Scaler asks for the next input sample |
| frame_restart | output | 1 | Synchronised restart, local to the video domain |
| scaler_valid | output | 1 | Input-valid to the scaler |
| fifo_rd_en | output | 1 | Read strobe to the FIFO |
| scaler_pixel | output | 24 | 8-8-8 sample to the scaler |

## Verification
On every cycle, the embedded properties check several things:
- the restart latency through the chain;
- that the counter is cleared while restart is high and frozen on empty cycles;
- that it never exceeds its limit;
- that the ready flag rises only at a full count;
- that a read never happens against an empty FIFO or before the prefill ends.

Some behaviours only the bench scenarios can show. The first valid arrives on the 62nd non-empty cycle even when empty cycles are scattered in between. The ready flag survives a long empty stretch. A mid-frame restart closes the gate five edges after it is raised, and then a full prefill is required again.

// File: rtl/frame_prefill_gate.sv
module frame_prefill_gate #(
  parameter int SYNC_STAGES    = 5,
  parameter int PREFILL_CYCLES = 60,
  parameter int RED_W          = 5,
  parameter int GRN_W          = 6,
  parameter int BLU_W          = 5,
  parameter int CH_W           = 8,
  localparam int IN_W          = RED_W + GRN_W + BLU_W,
  localparam int OUT_W         = 3 * CH_W,
  localparam int CNT_W         = $clog2(PREFILL_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_async,
  input  logic             fifo_empty,
  input  logic [IN_W-1:0]  fifo_rdata,
  input  logic             scaler_next,
  output logic             frame_restart,
  output logic             scaler_valid,
  output logic             fifo_rd_en,
  output logic [OUT_W-1:0] scaler_pixel
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(PREFILL_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       fill_cnt;
  logic                   ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], restart_async};
  end

  assign frame_restart = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      ready_q  <= 1'b0;
    end else if (frame_restart) begin
      fill_cnt <= '0;
      ready_q  <= 1'b0;
    end else if (!fifo_empty) begin
      if (fill_cnt < FULL) fill_cnt <= fill_cnt + 1'b1;
      if (fill_cnt == FULL) ready_q <= 1'b1;
    end
  end

  assign scaler_valid = !frame_restart && !fifo_empty && ready_q;
  assign fifo_rd_en   = scaler_next && scaler_valid;

  wire [RED_W-1:0] red_in = fifo_rdata[IN_W-1 -: RED_W];
  wire [GRN_W-1:0] grn_in = fifo_rdata[BLU_W +: GRN_W];
  wire [BLU_W-1:0] blu_in = fifo_rdata[BLU_W-1:0];

  assign scaler_pixel = {red_in, {(CH_W-RED_W){1'b0}},
                         grn_in, {(CH_W-GRN_W){1'b0}},
                         blu_in, {(CH_W-BLU_W){1'b0}}};

  p_sync_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_restart) || $fell(frame_restart)) |-> (frame_restart == $past(restart_async, SYNC_STAGES)));

  p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_restart |=> (fill_cnt == '0 && !ready_q));

  p_cnt_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= FULL);

  p_cnt_frozen_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_restart && fifo_empty) |=> $stable(fill_cnt));

  p_ready_at_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(fill_cnt) == FULL && !$past(fifo_empty)));

  p_valid_after_prefill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scaler_valid |-> fill_cnt == FULL);

  p_no_read_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> (!fifo_empty && ready_q));

  p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_restart |-> !fifo_rd_en);

endmodule

// File: tb/tb_frame_prefill_gate.sv
module tb_frame_prefill_gate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        restart_async = 0;
  logic        fifo_empty = 1;
  logic [15:0] fifo_rdata = 0;
  logic        scaler_next = 0;
  logic        frame_restart, scaler_valid, fifo_rd_en;
  logic [23:0] scaler_pixel;

  int checks = 0;
  int fails  = 0;

  frame_prefill_gate dut (
    .clk(clk), .rst_n(rst_n), .restart_async(restart_async),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .scaler_next(scaler_next),
    .frame_restart(frame_restart), .scaler_valid(scaler_valid),
    .fifo_rd_en(fifo_rd_en), .scaler_pixel(scaler_pixel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  bit   m_sync[$];
  int   m_cnt;
  bit   m_ready;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = '{0, 0, 0, 0, 0};
      m_cnt = 0;
      m_ready = 0;
    end else begin
      if (m_sync[4]) begin
        m_cnt = 0;
        m_ready = 0;
      end else if (!fifo_empty) begin
        if (m_cnt == 60) m_ready = 1;
        if (m_cnt < 60) m_cnt = m_cnt + 1;
      end
      m_sync.push_front(restart_async);
      void'(m_sync.pop_back());
    end
  end

  function automatic logic [23:0] widen(input logic [15:0] p);
    int r, g, b;
    r = (p >> 11) & 31;
    g = (p >> 5) & 63;
    b = p & 31;
    return 24'((r * 8) * 65536 + (g * 4) * 256 + b * 8);
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic er, ev;
    er = rst_n ? m_sync[4] : 1'b0;
    ev = !er && !fifo_empty && m_ready;
    check("R1 frame_restart", 24'(frame_restart), 24'(er));
    check("R5 scaler_valid", 24'(scaler_valid), 24'(ev));
    check("R6 fifo_rd_en", 24'(fifo_rd_en), 24'(ev && scaler_next));
    check("R7 scaler_pixel", scaler_pixel, widen(fifo_rdata));
  endtask

  logic [15:0] seed = 16'h1234;

  task automatic cyc(input logic rs, input logic em, input logic nx);
    @(negedge clk);
    compare_all();
    seed = seed * 16'd25173 + 16'd13849;
    restart_async = rs;
    fifo_empty = em;
    scaler_next = nx;
    fifo_rdata = seed;
    #1;
  endtask

  task automatic prefill_run(input string req, input bit gaps);
    int nonempty_low = 0;
    int early_reads = 0;
    for (int i = 0; i < 400; i++) begin
      logic em;
      em = gaps ? ((i % 4) == 3) : 1'b0;
      cyc(0, em, 1);
      if (fifo_rd_en && !scaler_valid) early_reads++;
      if (!em && !frame_restart) begin
        if (scaler_valid) break;
        if (fifo_rd_en) early_reads++;
        nonempty_low++;
      end
    end
    check({req, " prefill non-empty cycles"}, 24'(nonempty_low), 24'd61);
    check("R6 no read during prefill", 24'(early_reads), 24'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    check("R1 reset frame_restart", 24'(frame_restart), 24'd0);
    check("R5 reset scaler_valid", 24'(scaler_valid), 24'd0);
    rst_n = 1;

    prefill_run("R3", 1'b1);

    repeat (12) cyc(0, 1, 1);
    cyc(0, 0, 1);
    check("R4 ready kept over empty stretch", 24'(scaler_valid), 24'd1);
    check("R4 read after empty stretch", 24'(fifo_rd_en), 24'd1);
    cyc(0, 0, 0);
    check("R6 no read without request", 24'(fifo_rd_en), 24'd0);

    cyc(1, 0, 1);
    repeat (4) cyc(1, 0, 1);
    check("R8 gate open before sync delay", 24'(scaler_valid), 24'd1);
    cyc(1, 0, 1);
    check("R1 restart after five edges", 24'(frame_restart), 24'd1);
    check("R8 gate closed at restart", 24'(fifo_rd_en), 24'd0);
    for (int i = 0; i < 8; i++) begin
      cyc(1, 0, 1);
      check("R2 valid low during restart", 24'(scaler_valid), 24'd0);
    end
    cyc(0, 0, 1);
    repeat (4) cyc(0, 0, 1);
    check("R1 restart still high before fall", 24'(frame_restart), 24'd1);
    prefill_run("R2", 1'b0);

    fifo_rdata = 16'hFFFF; #1;
    check("R7 white", scaler_pixel, 24'hF8FCF8);
    fifo_rdata = 16'hF800; #1;
    check("R7 red", scaler_pixel, 24'hF80000);
    fifo_rdata = 16'h07E0; #1;
    check("R7 green", scaler_pixel, 24'h00FC00);
    fifo_rdata = 16'h001F; #1;
    check("R7 blue", scaler_pixel, 24'h0000F8);

    repeat (5) cyc(0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule